// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block is the software-facing register port of one eight-line interrupt controller. A host reaches it through two byte addresses, using single-cycle write and read strobes. Writes to the command address with bit 4 set start an initialization sequence. Later writes to the data address then step through a vector base word, an adjustment word and an optional mode word. After that sequence, data-address writes load the line mask. Other command-address writes are either mode commands (poll, readback select, special mask) or operation commands. The operation commands are coded in the top three data bits and cover end-of-interrupt, specific end-of-interrupt, rotation and priority-offset changes.

The priority resolver, the request latch and the in-service register are outside this block. The block takes from them two resolver results: the current winning request line and the highest-priority in-service line. It also takes the request and in-service vectors, for readback only. In return it drives the configuration state and one-cycle clear pulses that the surrounding logic applies to its in-service and request bits. A read while poll is armed returns the winning line and clears both of that line's bits, so the interrupt is consumed without an acknowledge cycle.

Top module: `pic_cmd_port`

## Requirements
- R1: A write to address 0 with data bit 4 set clears mask, vector base, rotation offset, read-select, poll, special-mask, auto-EOI, fully-nested and rotate-on-auto-EOI. It raises `init_clr_o` for exactly one cycle, enters the base step, and records data bit 0 as "mode word expected". Reset leaves the same cleared state, in the normal step.
- R2: In the base step, a data-address write sets the vector base to data AND 0xF8 and moves to the adjust step. In the adjust step, a data-address write moves to the mode step if the mode word is expected and to the normal step otherwise. Neither write changes the mask.
- R3: In the mode step, a data-address write sets fully-nested from data bit 4 and auto-EOI from data bit 1, then returns to the normal step.
- R4: In the normal step, a data-address write loads the mask with the full data byte. The mask does not change during the base, adjust and mode steps.
- R5: A write to address 0 with bit 4 clear and bit 3 set is a mode command. Bit 2 set arms poll, and bit 2 clear leaves poll unchanged. Bit 1 set loads bit 0 into read-select. Bit 6 set loads bit 5 into special-mask. Each field is left unchanged when its enable bit is clear.
- R6: Any other address-0 write is an operation, coded in bits 7:5. Codes 0 and 4 set rotate-on-auto-EOI to bit 7. Code 2 changes nothing and pulses no clear.
- R7: Code 1 pulses `isr_clr_o` one-hot at `isr_top_line` when `isr_top_vld` is 1, and pulses nothing when it is 0. Code 5 does the same and also sets the rotation offset to (that line + 1) mod 8.
- R8: Code 3 pulses `isr_clr_o` at line data[2:0]. Code 7 does the same and sets the offset to (data[2:0] + 1) mod 8. Code 6 sets the offset to (data[2:0] + 1) mod 8 and clears nothing.
- R9: A read while poll is armed disarms poll, whatever the address. With `win_vld` at 1 it returns `win_line` zero-extended and pulses both `irr_clr_o` and `isr_clr_o` one-hot at that line. With `win_vld` at 0 it returns 7 and pulses nothing.
- R10: A read without poll returns the mask from address 1. From address 0 it returns `isr_in` when read-select is 1 and `irr_in` when read-select is 0.
- R11: Read data and `rvalid_o` appear on the cycle after the read strobe. Clear pulses last one cycle. When write and read strobes coincide, the write is taken and the read is dropped, with no `rvalid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Register address: 0 command, 1 data |
| wdata | input | 8 | Write data |
| irr_in | input | 8 | Request vector, for readback |
| isr_in | input | 8 | In-service vector, for readback |
| win_vld | input | 1 | Resolver has a winning request |
| win_line | input | 3 | Winning request line |
| isr_top_vld | input | 1 | Some line is in service |
| isr_top_line | input | 3 | Highest-priority in-service line |
| mask_o | output | 8 | Line mask |
| vec_base_o | output | 8 | Vector base, low three bits zero |
| auto_eoi_o | output | 1 | Auto end-of-interrupt mode |
| nested_o | output | 1 | Fully-nested mode |
| special_mask_o | output | 1 | Special-mask mode |
| rot_aeoi_o | output | 1 | Rotate on auto end-of-interrupt |
| rot_offset_o | output | 3 | Priority rotation offset |
| init_clr_o | output | 1 | One-cycle pulse: clear request/in-service state |
| isr_clr_o | output | 8 | One-cycle in-service clear pulses |
| irr_clr_o | output | 8 | One-cycle request clear pulses |
| rdata_o | output | 8 | Read data |
| rvalid_o | output | 1 | Read data valid |

## Verification
The bench builds the block with its package defaults: eight lines, an 8-bit data byte and a 3-bit operation code. With these values every operation code can be driven, and the offset wrap from line 7 back to 0 is reached in the rotation commands. Both initialization paths are exercised, with and without the mode word. The bench also covers a poll with and without a winner, and a colliding read and write.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
    localparam int DW     = 8;
    localparam int LINES  = 8;
    localparam int LW     = $clog2(LINES);
    localparam int CODE_W = 3;
    localparam int OP_LSB = DW - CODE_W;

    // command-byte field positions
    localparam int B_INIT    = 4;
    localparam int B_MODECMD = 3;
    localparam int B_POLL    = 2;
    localparam int B_RSEL_EN = 1;
    localparam int B_RSEL    = 0;
    localparam int B_SMM_EN  = 6;
    localparam int B_SMM     = 5;
    localparam int B_NEED4   = 0;
    localparam int B_NESTED  = 4;
    localparam int B_AEOI    = 1;
    localparam int B_ROT     = DW - 1;

    typedef logic [DW-1:0]    byte_t;
    typedef logic [LW-1:0]    line_t;
    typedef logic [LINES-1:0] vec_t;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_BASE = 2'd1,
        ST_ADJ  = 2'd2,
        ST_MODE = 2'd3
    } init_step_e;

    typedef enum logic [CODE_W-1:0] {
        OP_ROT_OFF  = 3'd0,
        OP_EOI      = 3'd1,
        OP_NOP      = 3'd2,
        OP_EOI_LINE = 3'd3,
        OP_ROT_ON   = 3'd4,
        OP_EOI_ROT  = 3'd5,
        OP_SET_PRIO = 3'd6,
        OP_LINE_ROT = 3'd7
    } op_e;

    typedef struct packed {
        logic init;
        logic mode;
        logic op;
        logic data;
        logic rd;
    } access_t;

    typedef struct packed {
        logic auto_eoi;
        logic nested;
    } mode_t;

    function automatic vec_t line_bit(line_t l);
        return vec_t'(1) << l;
    endfunction

    function automatic line_t line_next(line_t l);
        return l + line_t'(1);
    endfunction

    function automatic byte_t base_of(byte_t d);
        return d & ~byte_t'(LINES - 1);
    endfunction
endpackage

// File: rtl/pic_access_dec.sv
module pic_access_dec
    import pic_cmd_pkg::*;
(
    input  logic    wr_en,
    input  logic    rd_en,
    input  logic    addr,
    input  byte_t   wdata,
    output access_t acc
);
    // one access per cycle; a write takes precedence over a read
    always_comb begin
        acc = '0;
        if (wr_en) begin
            if (addr)                  acc.data = 1'b1;
            else if (wdata[B_INIT])    acc.init = 1'b1;
            else if (wdata[B_MODECMD]) acc.mode = 1'b1;
            else                       acc.op   = 1'b1;
        end else if (rd_en) begin
            acc.rd = 1'b1;
        end
    end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  access_t    acc,
    input  byte_t      wdata,
    output byte_t      mask,
    output byte_t      base,
    output mode_t      mode,
    output logic       init_clr,
    output init_step_e step
);
    logic need4;

    always_ff @(posedge clk) begin
        if (rst) begin
            step     <= ST_RUN;
            need4    <= 1'b0;
            mask     <= '0;
            base     <= '0;
            mode     <= '0;
            init_clr <= 1'b0;
        end else begin
            init_clr <= acc.init;
            if (acc.init) begin
                step  <= ST_BASE;
                need4 <= wdata[B_NEED4];
                mask  <= '0;
                base  <= '0;
                mode  <= '0;
            end else if (acc.data) begin
                case (step)
                    ST_RUN:  mask <= wdata;
                    ST_BASE: begin
                        base <= base_of(wdata);
                        step <= ST_ADJ;
                    end
                    ST_ADJ:  step <= need4 ? ST_MODE : ST_RUN;
                    ST_MODE: begin
                        mode.nested   <= wdata[B_NESTED];
                        mode.auto_eoi <= wdata[B_AEOI];
                        step          <= ST_RUN;
                    end
                    default: step <= ST_RUN;
                endcase
            end
        end
    end

    p_init_clears_r1: assert property (@(posedge clk) disable iff (rst)
        acc.init |=> (mask == '0 && base == '0 && mode == '0 && step == ST_BASE && init_clr));

    p_base_step_r2: assert property (@(posedge clk) disable iff (rst)
        (acc.data && step == ST_BASE) |=> (step == ST_ADJ));

    p_mode_exit_r3: assert property (@(posedge clk) disable iff (rst)
        (acc.data && step == ST_MODE) |=> (step == ST_RUN));

    p_mask_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (step != ST_RUN && !acc.init) |=> $stable(mask));
endmodule

// File: rtl/pic_op_exec.sv
module pic_op_exec
    import pic_cmd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  access_t acc,
    input  byte_t   wdata,
    input  logic    isr_top_vld,
    input  line_t   isr_top_line,
    output logic    rot_aeoi,
    output line_t   offset,
    output logic    read_sel,
    output logic    special_mask,
    output vec_t    isr_clr
);
    op_e   op;
    line_t cmd_line;

    assign op       = op_e'(wdata[DW-1:OP_LSB]);
    assign cmd_line = wdata[LW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rot_aeoi     <= 1'b0;
            offset       <= '0;
            read_sel     <= 1'b0;
            special_mask <= 1'b0;
            isr_clr      <= '0;
        end else begin
            isr_clr <= '0;
            if (acc.init) begin
                rot_aeoi     <= 1'b0;
                offset       <= '0;
                read_sel     <= 1'b0;
                special_mask <= 1'b0;
            end else if (acc.mode) begin
                if (wdata[B_RSEL_EN]) read_sel     <= wdata[B_RSEL];
                if (wdata[B_SMM_EN])  special_mask <= wdata[B_SMM];
            end else if (acc.op) begin
                case (op)
                    OP_ROT_OFF, OP_ROT_ON: rot_aeoi <= wdata[B_ROT];
                    OP_EOI, OP_EOI_ROT: begin
                        if (isr_top_vld) begin
                            isr_clr <= line_bit(isr_top_line);
                            if (op == OP_EOI_ROT) offset <= line_next(isr_top_line);
                        end
                    end
                    OP_EOI_LINE: isr_clr <= line_bit(cmd_line);
                    OP_SET_PRIO: offset  <= line_next(cmd_line);
                    OP_LINE_ROT: begin
                        isr_clr <= line_bit(cmd_line);
                        offset  <= line_next(cmd_line);
                    end
                    default: ;
                endcase
            end
        end
    end

    p_nop_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (acc.op && op == OP_NOP) |=> ($stable(offset) && $stable(rot_aeoi) && isr_clr == '0));

    p_eoi_empty_r7: assert property (@(posedge clk) disable iff (rst)
        (acc.op && (op == OP_EOI || op == OP_EOI_ROT) && !isr_top_vld) |=> (isr_clr == '0));

    p_prio_noclr_r8: assert property (@(posedge clk) disable iff (rst)
        (acc.op && op == OP_SET_PRIO) |=> (isr_clr == '0));

    p_clr_single_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(isr_clr));
endmodule

// File: rtl/pic_read_path.sv
module pic_read_path
    import pic_cmd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  access_t acc,
    input  byte_t   wdata,
    input  logic    addr,
    input  logic    read_sel,
    input  byte_t   mask,
    input  vec_t    irr_in,
    input  vec_t    isr_in,
    input  logic    win_vld,
    input  line_t   win_line,
    output byte_t   rdata,
    output logic    rvalid,
    output vec_t    irr_clr,
    output vec_t    isr_clr
);
    logic poll;

    always_ff @(posedge clk) begin
        if (rst) begin
            poll    <= 1'b0;
            rdata   <= '0;
            rvalid  <= 1'b0;
            irr_clr <= '0;
            isr_clr <= '0;
        end else begin
            rvalid  <= acc.rd;
            irr_clr <= '0;
            isr_clr <= '0;
            if (acc.init) begin
                poll <= 1'b0;
            end else if (acc.mode && wdata[B_POLL]) begin
                poll <= 1'b1;
            end
            if (acc.rd) begin
                if (poll) begin
                    poll <= 1'b0;
                    if (win_vld) begin
                        rdata   <= byte_t'(win_line);
                        irr_clr <= line_bit(win_line);
                        isr_clr <= line_bit(win_line);
                    end else begin
                        rdata <= byte_t'(LINES - 1);
                    end
                end else begin
                    rdata <= addr ? mask : (read_sel ? isr_in : irr_in);
                end
            end
        end
    end

    p_poll_disarm_r9: assert property (@(posedge clk) disable iff (rst)
        acc.rd |=> !poll);

    p_poll_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && poll && !win_vld) |=> (irr_clr == '0 && rdata == byte_t'(LINES - 1)));

    p_rvalid_on_r11: assert property (@(posedge clk) disable iff (rst)
        acc.rd |=> rvalid);

    p_rvalid_off_r11: assert property (@(posedge clk) disable iff (rst)
        !acc.rd |=> !rvalid);
endmodule

// File: rtl/pic_cmd_port.sv
module pic_cmd_port
    import pic_cmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic                  addr,
    input  logic [DW-1:0]         wdata,
    input  logic [LINES-1:0]      irr_in,
    input  logic [LINES-1:0]      isr_in,
    input  logic                  win_vld,
    input  logic [LW-1:0]         win_line,
    input  logic                  isr_top_vld,
    input  logic [LW-1:0]         isr_top_line,
    output logic [DW-1:0]         mask_o,
    output logic [DW-1:0]         vec_base_o,
    output logic                  auto_eoi_o,
    output logic                  nested_o,
    output logic                  special_mask_o,
    output logic                  rot_aeoi_o,
    output logic [LW-1:0]         rot_offset_o,
    output logic                  init_clr_o,
    output logic [LINES-1:0]      isr_clr_o,
    output logic [LINES-1:0]      irr_clr_o,
    output logic [DW-1:0]         rdata_o,
    output logic                  rvalid_o
);
    access_t    acc;
    mode_t      mode;
    init_step_e step;
    logic       read_sel;
    vec_t       op_isr_clr;
    vec_t       poll_isr_clr;

    pic_access_dec u_dec (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .acc   (acc)
    );

    pic_init_seq u_init (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .wdata    (wdata),
        .mask     (mask_o),
        .base     (vec_base_o),
        .mode     (mode),
        .init_clr (init_clr_o),
        .step     (step)
    );

    pic_op_exec u_op (
        .clk          (clk),
        .rst          (rst),
        .acc          (acc),
        .wdata        (wdata),
        .isr_top_vld  (isr_top_vld),
        .isr_top_line (isr_top_line),
        .rot_aeoi     (rot_aeoi_o),
        .offset       (rot_offset_o),
        .read_sel     (read_sel),
        .special_mask (special_mask_o),
        .isr_clr      (op_isr_clr)
    );

    pic_read_path u_rd (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .wdata    (wdata),
        .addr     (addr),
        .read_sel (read_sel),
        .mask     (mask_o),
        .irr_in   (irr_in),
        .isr_in   (isr_in),
        .win_vld  (win_vld),
        .win_line (win_line),
        .rdata    (rdata_o),
        .rvalid   (rvalid_o),
        .irr_clr  (irr_clr_o),
        .isr_clr  (poll_isr_clr)
    );

    assign auto_eoi_o = mode.auto_eoi;
    assign nested_o   = mode.nested;
    assign isr_clr_o  = op_isr_clr | poll_isr_clr;

    p_clr_disjoint_r11: assert property (@(posedge clk) disable iff (rst)
        (op_isr_clr & poll_isr_clr) == '0);

    p_init_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        init_clr_o |=> (!init_clr_o || $past(acc.init)));

    p_init_step_r1: assert property (@(posedge clk) disable iff (rst)
        init_clr_o |-> (step == ST_BASE || $past(acc.data)));
endmodule

// File: tb/tb_pic_cmd_port.sv
module tb_pic_cmd_port;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, rd_en, addr;
    logic [7:0] wdata, irr_in, isr_in;
    logic       win_vld, isr_top_vld;
    logic [2:0] win_line, isr_top_line;
    logic [7:0] mask_o, vec_base_o, isr_clr_o, irr_clr_o, rdata_o;
    logic       auto_eoi_o, nested_o, special_mask_o, rot_aeoi_o, init_clr_o, rvalid_o;
    logic [2:0] rot_offset_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] mon_e;
    string      mon_t;

    always #5 clk = ~clk;

    pic_cmd_port dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .irr_in(irr_in), .isr_in(isr_in), .win_vld(win_vld), .win_line(win_line),
        .isr_top_vld(isr_top_vld), .isr_top_line(isr_top_line),
        .mask_o(mask_o), .vec_base_o(vec_base_o), .auto_eoi_o(auto_eoi_o), .nested_o(nested_o),
        .special_mask_o(special_mask_o), .rot_aeoi_o(rot_aeoi_o), .rot_offset_o(rot_offset_o),
        .init_clr_o(init_clr_o), .isr_clr_o(isr_clr_o), .irr_clr_o(irr_clr_o),
        .rdata_o(rdata_o), .rvalid_o(rvalid_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // driver: one write; outputs are sampled at the returning negedge
    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: one read; expected data goes to the scoreboard queue
    task automatic rd(input logic a, input logic [7:0] e, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor: compares read data as the design returns it
    always @(negedge clk) begin
        if (!rst && rvalid_o) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL R11: unexpected read data actual %0h expected none", rdata_o);
            end else begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                chk(mon_t, {24'd0, rdata_o}, {24'd0, mon_e});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
        irr_in = 8'h3C; isr_in = 8'h81;
        win_vld = 0; win_line = 0; isr_top_vld = 0; isr_top_line = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset mask", mask_o, 0);
        chk("R1 reset base", vec_base_o, 0);
        chk("R1 reset flags", {auto_eoi_o, nested_o, special_mask_o, rot_aeoi_o, rot_offset_o}, 0);
        chk("R11 reset rvalid", rvalid_o, 0);

        // initialization with mode word
        wr(0, 8'h11);
        chk("R1 init pulse", init_clr_o, 1);
        wr(1, 8'h4D);
        chk("R2 base", vec_base_o, 8'h48);
        chk("R11 init pulse one cycle", init_clr_o, 0);
        wr(1, 8'hFF);
        chk("R2 adjust word keeps mask", mask_o, 0);
        wr(1, 8'h12);
        chk("R3 mode word", {nested_o, auto_eoi_o}, 2'b11);
        chk("R4 mask frozen in init", mask_o, 0);
        wr(1, 8'hA5);
        chk("R4 mask load", mask_o, 8'hA5);
        rd(1, 8'hA5, "R10 mask read");
        chk("R11 rvalid on cycle after", rvalid_o, 1);
        @(negedge clk);
        chk("R11 rvalid drops", rvalid_o, 0);

        // readback select
        rd(0, 8'h3C, "R10 request read");
        wr(0, 8'h0B);
        rd(0, 8'h81, "R5 read-select set");
        wr(0, 8'h09);
        rd(0, 8'h81, "R5 read-select ignored without enable");
        wr(0, 8'h0A);
        rd(0, 8'h3C, "R10 read-select cleared");

        // special mask
        wr(0, 8'h68);
        chk("R5 special mask set", special_mask_o, 1);
        wr(0, 8'h28);
        chk("R5 special mask ignored without enable", special_mask_o, 1);
        wr(0, 8'h48);
        chk("R5 special mask clear", special_mask_o, 0);

        // rotate flag and no-op
        wr(0, 8'h80);
        chk("R6 code 4 sets rotate", rot_aeoi_o, 1);
        wr(0, 8'h00);
        chk("R6 code 0 clears rotate", rot_aeoi_o, 0);
        wr(0, 8'h80);
        wr(0, 8'h47);
        chk("R6 code 2 no effect", {rot_aeoi_o, rot_offset_o, isr_clr_o}, {1'b1, 3'd0, 8'h00});

        // priority offset and specific clears
        wr(0, 8'hC5);
        chk("R8 code 6 offset", rot_offset_o, 6);
        chk("R8 code 6 no clear", isr_clr_o, 0);
        wr(0, 8'hC7);
        chk("R8 code 6 wrap", rot_offset_o, 0);
        wr(0, 8'h62);
        chk("R8 code 3 clear", isr_clr_o, 8'h04);
        chk("R8 code 3 offset kept", rot_offset_o, 0);
        @(negedge clk);
        chk("R11 clear pulse one cycle", isr_clr_o, 0);
        wr(0, 8'hE4);
        chk("R8 code 7 clear", isr_clr_o, 8'h10);
        chk("R8 code 7 offset", rot_offset_o, 5);

        // end-of-interrupt from resolver
        isr_top_vld = 1; isr_top_line = 3;
        wr(0, 8'h20);
        chk("R7 code 1 clear", isr_clr_o, 8'h08);
        chk("R7 code 1 offset kept", rot_offset_o, 5);
        isr_top_vld = 0;
        wr(0, 8'h20);
        chk("R7 code 1 nothing in service", isr_clr_o, 0);
        isr_top_vld = 1; isr_top_line = 7;
        wr(0, 8'hA0);
        chk("R7 code 5 clear", isr_clr_o, 8'h80);
        chk("R7 code 5 offset wrap", rot_offset_o, 0);
        isr_top_line = 2;
        wr(0, 8'hA0);
        chk("R7 code 5 offset", rot_offset_o, 3);
        isr_top_vld = 0;

        // poll
        wr(0, 8'h0C);
        win_vld = 1; win_line = 5;
        rd(0, 8'h05, "R9 poll winner");
        chk("R9 poll request clear", irr_clr_o, 8'h20);
        chk("R9 poll in-service clear", isr_clr_o, 8'h20);
        rd(0, 8'h3C, "R9 poll disarmed");
        wr(0, 8'h0C);
        win_vld = 0;
        rd(1, 8'h07, "R9 poll empty");
        chk("R9 poll empty no clear", {irr_clr_o, isr_clr_o}, 0);
        rd(1, 8'hA5, "R9 mask after poll");

        // collision: write wins
        @(negedge clk);
        wr_en = 1; rd_en = 1; addr = 1; wdata = 8'h5A;
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        chk("R11 collision write taken", mask_o, 8'h5A);
        chk("R11 collision read dropped", rvalid_o, 0);

        // re-init from a busy state, no mode word
        wr(0, 8'h0F);
        wr(0, 8'h68);
        wr(0, 8'h10);
        chk("R1 init clears mask base", {mask_o, vec_base_o}, 0);
        chk("R1 init clears flags",
            {auto_eoi_o, nested_o, special_mask_o, rot_aeoi_o, rot_offset_o}, 0);
        chk("R1 init pulse again", init_clr_o, 1);
        wr(1, 8'h37);
        chk("R2 base second", vec_base_o, 8'h30);
        wr(1, 8'h12);
        chk("R2 no mode word expected", nested_o, 0);
        wr(1, 8'h99);
        chk("R4 mask after short init", mask_o, 8'h99);
        rd(1, 8'h99, "R1 poll cleared by init");
        rd(0, 8'h3C, "R1 read-select cleared by init");

        repeat (2) @(negedge clk);
        chk("R11 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule